// File: doc/BRIEF.md
# Standby Entry and Wake Controller

This block runs the low-power standby sequence of a device. When an idle request is accepted, the system clock enable stays on for a fixed drain window so in-flight work can settle, then drops and the block reports standby. While in standby, it watches an active-low wake line for a high-to-low transition. It checks that the line stays low for a minimum number of input-clock cycles. That count is either programmable from a 6-bit setting or fixed at twelve when programmable qualification is off.

Once the wake pulse has qualified, the block waits a recovery latency before it restores the clock. The latency is short when the memory being executed from stayed active and long when that memory was asleep. The clock enable returns together with a one-cycle resume pulse, and after that the surrounding logic may service interrupts. A wake pulse that releases early returns the block to standby with its count discarded.

Top module: `standby_ctrl`

## Requirements
- R1: After reset, clk_en is 1, in_standby is 0 and resume is 0.
- R2: An idle_req sampled high while running keeps clk_en at 1 for exactly FLUSH_CYCLES (default 32) further cycles. After that, clk_en is 0 and in_standby is 1.
- R3: Wake is recognised only on a 1-to-0 transition of wake_n seen while in standby. A wake_n that is already low when standby begins does not wake the block.
- R4: With qual_en=1, wake_n must be sampled low for 2+qual_sel consecutive cycles, counting the first low sample. With qual_en=0 it must be low for 12 cycles. qual_sel is captured at the first low sample.
- R5: If wake_n returns high before the required count is reached, the block goes back to standby and clk_en stays 0. A later falling edge starts a new count from one.
- R6: After qualification completes, the block waits 12 cycles if mem_sleep=0 or 1125 cycles if mem_sleep=1 before clk_en returns to 1. mem_sleep is sampled when qualification completes. Counted in clock edges from the first low sample of wake_n, clk_en returns after (required width + latency) edges.
- R7: resume is high for exactly one cycle, and that cycle is the first cycle in which clk_en is 1 again.
- R8: idle_req has no effect in any state other than running. Holding it high during the drain window, in standby, during qualification or during recovery changes neither the drain length nor the wake timing.
- R9: After resume, a fresh idle_req starts a new drain-and-standby sequence with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_req | input | 1 | Request to enter standby, sampled while running |
| wake_n | input | 1 | Active-low external wake line |
| qual_sel | input | 6 | Programmable qualification setting (required width minus two) |
| qual_en | input | 1 | Selects programmable qualification (1) or the fixed 12-cycle width (0) |
| mem_sleep | input | 1 | Executing memory was asleep; selects the long recovery latency |
| clk_en | output | 1 | System clock enable |
| in_standby | output | 1 | High from clock gating until the clock is restored |
| resume | output | 1 | One-cycle pulse marking the restoration of the clock |

## Verification
The bench builds the block with its default parameters: a 32-cycle drain, a 6-bit setting, and latencies of 12 and 1125 cycles. These sizes keep every qualification setting within reach, so the bench sweeps all 64 values against the active-memory latency and compares each wake-to-clock distance against 2+setting+12. It also checks the fixed 12-cycle width, the 1125-cycle path for sleeping memory, wake pulses one cycle too short, a wake line held low across entry, and idle requests held through every non-running state.

// File: rtl/standby_pkg.sv
package standby_pkg;

   typedef enum logic [2:0] {
      ST_RUN       = 3'd0,
      ST_FLUSH     = 3'd1,
      ST_STANDBY   = 3'd2,
      ST_QUALIFY   = 3'd3,
      ST_WAKE_WAIT = 3'd4
   } stby_state_t;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/standby_fall_detect.sv
module standby_fall_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic line_n,
   output logic fall
);
   logic line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= 1'b1;
      else        line_q <= line_n;
   end

   assign fall = line_q & ~line_n;
endmodule

// File: rtl/standby_counter.sv
module standby_counter #(
   parameter int unsigned W = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         inc,
   output logic [W-1:0] count
);
   if (W < 2) begin : g_bad_w
      $error("standby_counter: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (ld)  count <= ld_val;
      else if (inc) count <= count + 1'b1;
   end
endmodule

// File: rtl/standby_window_sel.sv
module standby_window_sel #(
   parameter int unsigned CNT_W        = 11,
   parameter int unsigned QSEL_W       = 6,
   parameter int unsigned QUAL_OFFSET  = 2,
   parameter int unsigned RAW_WIDTH    = 12,
   parameter int unsigned ACTIVE_LAT   = 12,
   parameter int unsigned SLEEP_LAT    = 1125,
   parameter bit          QUAL_SUPPORT = 1'b1
) (
   input  logic [QSEL_W-1:0] qual_sel,
   input  logic              qual_en,
   input  logic              mem_sleep,
   output logic [CNT_W-1:0]  need,
   output logic [CNT_W-1:0]  lat
);
   localparam logic [CNT_W-1:0] RAW_V    = CNT_W'(RAW_WIDTH);
   localparam logic [CNT_W-1:0] OFFS_V   = CNT_W'(QUAL_OFFSET);
   localparam logic [CNT_W-1:0] ACTIVE_V = CNT_W'(ACTIVE_LAT);
   localparam logic [CNT_W-1:0] SLEEP_V  = CNT_W'(SLEEP_LAT);

   if (QUAL_SUPPORT) begin : g_prog_qual
      always_comb begin
         if (qual_en) need = OFFS_V + CNT_W'(qual_sel);
         else         need = RAW_V;
      end
   end else begin : g_fixed_qual
      logic unused_qual;
      assign unused_qual = qual_en ^ (^qual_sel);
      assign need = RAW_V;
   end

   assign lat = mem_sleep ? SLEEP_V : ACTIVE_V;
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl #(
   parameter int unsigned FLUSH_CYCLES = 32,
   parameter int unsigned QSEL_W       = 6,
   parameter int unsigned QUAL_OFFSET  = 2,
   parameter int unsigned RAW_WIDTH    = 12,
   parameter int unsigned ACTIVE_LAT   = 12,
   parameter int unsigned SLEEP_LAT    = 1125,
   parameter bit          QUAL_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idle_req,
   input  logic              wake_n,
   input  logic [QSEL_W-1:0] qual_sel,
   input  logic              qual_en,
   input  logic              mem_sleep,
   output logic              clk_en,
   output logic              in_standby,
   output logic              resume
);
   import standby_pkg::*;

   localparam int unsigned QUAL_MAX = QUAL_OFFSET + (2 ** QSEL_W) - 1;
   localparam int unsigned MAXV     = max3(max3(FLUSH_CYCLES, QUAL_MAX, RAW_WIDTH),
                                           ACTIVE_LAT, SLEEP_LAT);
   localparam int unsigned CNT_W    = $clog2(MAXV + 1);
   localparam logic [CNT_W-1:0] FLUSH_LAST = CNT_W'(FLUSH_CYCLES - 1);
   localparam logic [CNT_W-1:0] ONE_V      = CNT_W'(1);

   if (FLUSH_CYCLES < 1) begin : g_bad_flush
      $error("standby_ctrl: FLUSH_CYCLES must be at least 1");
   end
   if (QUAL_OFFSET < 2) begin : g_bad_offset
      $error("standby_ctrl: QUAL_OFFSET must be at least 2");
   end
   if (RAW_WIDTH < 2) begin : g_bad_raw
      $error("standby_ctrl: RAW_WIDTH must be at least 2");
   end
   if (ACTIVE_LAT < 1 || SLEEP_LAT < 1) begin : g_bad_lat
      $error("standby_ctrl: latencies must be at least 1");
   end

   stby_state_t state, state_nx;
   logic [CNT_W-1:0] cnt, ld_val;
   logic [CNT_W-1:0] need_w, lat_w, need_q, lat_q;
   logic ld, inc, need_ld, lat_ld, resume_d, fall;

   standby_fall_detect u_fall (
      .clk   (clk),
      .rst_n (rst_n),
      .line_n(wake_n),
      .fall  (fall)
   );

   standby_window_sel #(
      .CNT_W       (CNT_W),
      .QSEL_W      (QSEL_W),
      .QUAL_OFFSET (QUAL_OFFSET),
      .RAW_WIDTH   (RAW_WIDTH),
      .ACTIVE_LAT  (ACTIVE_LAT),
      .SLEEP_LAT   (SLEEP_LAT),
      .QUAL_SUPPORT(QUAL_SUPPORT)
   ) u_sel (
      .qual_sel (qual_sel),
      .qual_en  (qual_en),
      .mem_sleep(mem_sleep),
      .need     (need_w),
      .lat      (lat_w)
   );

   standby_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (ld),
      .ld_val(ld_val),
      .inc   (inc),
      .count (cnt)
   );

   always_comb begin
      state_nx = state;
      ld       = 1'b0;
      ld_val   = '0;
      inc      = 1'b0;
      need_ld  = 1'b0;
      lat_ld   = 1'b0;
      resume_d = 1'b0;
      unique case (state)
         ST_RUN: begin
            if (idle_req) begin
               state_nx = ST_FLUSH;
               ld       = 1'b1;
            end
         end
         ST_FLUSH: begin
            if (cnt == FLUSH_LAST) state_nx = ST_STANDBY;
            else                   inc      = 1'b1;
         end
         ST_STANDBY: begin
            if (fall) begin
               state_nx = ST_QUALIFY;
               ld       = 1'b1;
               ld_val   = ONE_V;
               need_ld  = 1'b1;
            end
         end
         ST_QUALIFY: begin
            if (wake_n) begin
               state_nx = ST_STANDBY;
            end else if (cnt == need_q - ONE_V) begin
               state_nx = ST_WAKE_WAIT;
               ld       = 1'b1;
               lat_ld   = 1'b1;
            end else begin
               inc = 1'b1;
            end
         end
         ST_WAKE_WAIT: begin
            if (cnt == lat_q - ONE_V) begin
               state_nx = ST_RUN;
               resume_d = 1'b1;
            end else begin
               inc = 1'b1;
            end
         end
         default: state_nx = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_RUN;
         need_q <= ONE_V + ONE_V;
         lat_q  <= ONE_V;
         resume <= 1'b0;
      end else begin
         state  <= state_nx;
         resume <= resume_d;
         if (need_ld) need_q <= need_w;
         if (lat_ld)  lat_q  <= lat_w;
      end
   end

   assign in_standby = (state == ST_STANDBY) || (state == ST_QUALIFY) ||
                       (state == ST_WAKE_WAIT);
   assign clk_en     = ~in_standby;

   // R2: the drain window ends on its last count and the clock is then gated
   assert_flush_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FLUSH && cnt == FLUSH_LAST) |=> (in_standby && !clk_en));

   // R2: the drain counter never runs past its window
   assert_flush_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FLUSH) |-> (cnt < CNT_W'(FLUSH_CYCLES)));

   // R3: standby is left only after a falling edge on the wake line
   assert_edge_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STANDBY && !fall) |=> (state == ST_STANDBY));

   // R5: an early release returns to standby
   assert_qual_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_QUALIFY && wake_n) |=> (state == ST_STANDBY));

   // R7: resume coincides with clock restoration and lasts one cycle
   assert_resume_clk_R7: assert property (@(posedge clk) disable iff (!rst_n)
      resume |-> (clk_en && $past(in_standby)));
   assert_resume_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      resume |=> !resume);

   // R8: idle requests cannot pull the block out of the drain window early
   assert_idle_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FLUSH && cnt != FLUSH_LAST) |=> (state == ST_FLUSH));
endmodule

// File: tb/standby_ctrl_tb.sv
module standby_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       idle_req = 1'b0;
   logic       wake_n = 1'b1;
   logic [5:0] qual_sel = 6'd0;
   logic       qual_en = 1'b1;
   logic       mem_sleep = 1'b0;
   logic       clk_en, in_standby, resume;

   int checks = 0;
   int fails  = 0;

   localparam int FLUSH  = 32;
   localparam int RAW    = 12;
   localparam int LAT_A  = 12;
   localparam int LAT_S  = 1125;

   always #5 clk = ~clk;

   standby_ctrl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .idle_req  (idle_req),
      .wake_n    (wake_n),
      .qual_sel  (qual_sel),
      .qual_en   (qual_en),
      .mem_sleep (mem_sleep),
      .clk_en    (clk_en),
      .in_standby(in_standby),
      .resume    (resume)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // caller is at a negedge; R2 / R8 drain check
   task automatic enter_standby(input bit hold_idle, input string req);
      int n;
      idle_req = 1'b1;
      @(posedge clk); @(negedge clk);
      if (!hold_idle) idle_req = 1'b0;
      n = 0;
      while (clk_en && n < 100) begin
         n++;
         @(posedge clk); @(negedge clk);
      end
      idle_req = 1'b0;
      chk(req, n, FLUSH);
      chk(req, int'(in_standby), 1);
   endtask

   // caller is at a negedge in standby; R4 / R6 / R7 timing
   task automatic do_wake(input int need, input int lat, input bit hold_idle,
                          input string req);
      int n;
      wake_n = 1'b0;
      if (hold_idle) idle_req = 1'b1;
      n = 0;
      do begin
         @(posedge clk); @(negedge clk);
         n++;
      end while (!clk_en && n < 3000);
      idle_req = 1'b0;
      chk(req, n, need + lat);
      chk("R7", int'(resume), 1);
      chk("R7", int'(in_standby), 0);
      wake_n = 1'b1;
      @(posedge clk); @(negedge clk);
      chk("R7", int'(resume), 0);
      chk("R9", int'(clk_en), 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", int'(clk_en), 1);
      chk("R1", int'(in_standby), 0);
      chk("R1", int'(resume), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 / R6: sweep every qualification setting, active memory
      qual_en = 1'b1;
      mem_sleep = 1'b0;
      for (int s = 0; s < 64; s++) begin
         qual_sel = 6'(s);
         enter_standby(1'b0, "R2");
         do_wake(2 + s, LAT_A, 1'b0, "R4");
      end

      // R4: fixed width when programmable qualification is off
      qual_en = 1'b0;
      qual_sel = 6'd40;
      enter_standby(1'b0, "R2");
      do_wake(RAW, LAT_A, 1'b0, "R4");

      // R6: sleeping memory, both qualification modes
      mem_sleep = 1'b1;
      enter_standby(1'b0, "R2");
      do_wake(RAW, LAT_S, 1'b0, "R6");
      qual_en = 1'b1;
      qual_sel = 6'd5;
      enter_standby(1'b0, "R2");
      do_wake(7, LAT_S, 1'b0, "R6");
      mem_sleep = 1'b0;

      // R5: pulse one cycle short, then a fresh full pulse
      for (int s = 0; s < 64; s += 21) begin
         qual_sel = 6'(s);
         enter_standby(1'b0, "R2");
         wake_n = 1'b0;
         repeat (s + 1) @(negedge clk);
         wake_n = 1'b1;
         repeat (20) @(negedge clk);
         chk("R5", int'(clk_en), 0);
         chk("R5", int'(in_standby), 1);
         do_wake(2 + s, LAT_A, 1'b0, "R5");
      end

      // R3: wake line already low across entry does not wake
      qual_sel = 6'd3;
      wake_n = 1'b0;
      @(negedge clk);
      enter_standby(1'b0, "R2");
      repeat (60) @(negedge clk);
      chk("R3", int'(in_standby), 1);
      chk("R3", int'(clk_en), 0);
      wake_n = 1'b1;
      @(negedge clk);
      do_wake(5, LAT_A, 1'b0, "R3");

      // R8: idle request held through drain, standby, qualify and recovery
      qual_sel = 6'd9;
      enter_standby(1'b1, "R8");
      idle_req = 1'b1;
      repeat (10) @(negedge clk);
      chk("R8", int'(in_standby), 1);
      do_wake(11, LAT_A, 1'b1, "R8");
      mem_sleep = 1'b1;
      enter_standby(1'b1, "R8");
      do_wake(11, LAT_S, 1'b1, "R8");

      // R9: back-to-back sequence after resume
      mem_sleep = 1'b0;
      enter_standby(1'b0, "R9");
      do_wake(11, LAT_A, 1'b0, "R9");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule